// File: doc/BRIEF.md
# Machine Cycle Status Sequencer

This block runs the external bus cycles of a small 8-bit processor. A cycle request names one of five cycle kinds and carries an address and, for writes, a data byte. The sequencer then steps through numbered clock states and drives the bus control outputs in each one. A three-bit status code (io_m, s1, s0) identifies the running cycle to the outside world. The block also drives an address latch strobe, active-low read and write strobes, a state number and a one-cycle completion pulse. It captures the byte that is read back.

An opcode fetch takes four states. Its fourth state is left free of bus activity so the core can decode. Every other kind takes three states. Between two cycles there is always at least one idle state, and a new request is taken only there. Requests are encoded on `req_kind` as 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. The codes 5 to 7 are invalid. Every instruction must begin with a fetch, so after reset the block will not start any other kind of cycle until a fetch has run.

Top module: `mcycle_seq`

## Requirements
- R1: The status triple {io_m,s1,s0} takes its cycle value in state 1. It holds that value unchanged through the last state of the cycle: memory read 010, memory write 001, I/O read 110, I/O write 101.
- R2: An opcode fetch (req_kind 0) shows status 011 and runs exactly four states, 1 to 4. In state 4 both rd_n and wr_n are high.
- R3: Memory read, memory write, I/O read and I/O write cycles run exactly three states.
- R4: When idle, the block shows tstate = 0, status 000, rd_n = wr_n = 1, ale = 0, done = 0, and addr_out and data_out are both zero.
- R5: ale is high only in state 1. addr_out carries the requested address from state 1 through the last state.
- R6: rd_n is low in states 2 and 3 of fetch and read cycles. wr_n is low in states 2 and 3 of write cycles. data_out carries the write byte for the whole of a write cycle and is zero otherwise.
- R7: For fetch and read cycles, data_in is captured at the end of state 3. It is seen on rdata from the following state onward and held until the next read-type cycle captures again.
- R8: done is high for exactly one state, the last state of each cycle, and the next state is idle.
- R9: A request made while a cycle is running has no effect, and neither does a request with req_kind 5 to 7. A new cycle never starts in the state right after a busy state.
- R10: After reset, a request of any kind other than a fetch is ignored until a fetch has been accepted.
- R11: A synchronous active-high reset returns the block to the idle outputs of R4 with rdata = 0, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request, sampled only while idle |
| req_kind | input | 3 | Cycle kind code (0 fetch .. 4 I/O write) |
| req_addr | input | AW | Address for the requested cycle |
| req_wdata | input | DW | Byte to write for write cycles |
| data_in | input | DW | Byte returned by memory or I/O |
| io_m | output | 1 | Status: 1 for I/O cycle, 0 for memory cycle |
| s1 | output | 1 | Status bit s1 |
| s0 | output | 1 | Status bit s0 |
| ale | output | 1 | Address latch strobe, high in state 1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| tstate | output | TW | Current state number, 0 when idle |
| addr_out | output | AW | Address driven during a cycle |
| data_out | output | DW | Write byte driven during a write cycle |
| rdata | output | DW | Byte captured at the end of state 3 |
| done | output | 1 | High in the last state of a cycle |

## Verification
The hardest case to reach is a request that arrives while a cycle is already running. It must be ignored, yet a request held until the idle state that follows must be honoured. The stimulus covers this by keeping req_valid high with a different random kind through every state of some cycles and dropping it only at the idle state. The bench then checks that the status and length of the running cycle never change. The lock-out of non-fetch kinds after reset is only visible straight after reset, so the bench asserts reset in the middle of a cycle and then tries a read before any fetch.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MEMRD = 3'd1,
    K_MEMWR = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return (k <= 3'd4);
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] status_of(input kind_e k);
    case (k)
      K_FETCH: return 3'b011;
      K_MEMRD: return 3'b010;
      K_MEMWR: return 3'b001;
      K_IORD:  return 3'b110;
      K_IOWR:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic is_rd(input kind_e k);
    return (k == K_FETCH) || (k == K_MEMRD) || (k == K_IORD);
  endfunction

  function automatic logic is_wr(input kind_e k);
    return (k == K_MEMWR) || (k == K_IOWR);
  endfunction

endpackage

// File: rtl/bcs_phase_ctr.sv
module bcs_phase_ctr #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic [TW-1:0] t_q,
  output logic [TW-1:0] t_n
);

  localparam logic [TW-1:0] T_IDLE = '0;
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  always_comb begin
    if (t_q == T_IDLE)    t_n = start ? T_ONE : T_IDLE;
    else if (t_q == len)  t_n = T_IDLE;
    else                  t_n = t_q + T_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) t_q <= T_IDLE;
    else     t_q <= t_n;
  end

  // R3: inside a cycle the state number advances by one per clock
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (t_q != T_IDLE && t_q != len) |=> (t_q == $past(t_q) + T_ONE));

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] t_n,
  input  logic [TW-1:0] len_n,
  input  kind_e         kind_n,
  output logic [2:0]    status,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done
);

  localparam logic [TW-1:0] T_IDLE   = '0;
  localparam logic [TW-1:0] T_ADDR   = TW'(1);
  localparam logic [TW-1:0] T_STB_LO = TW'(2);
  localparam logic [TW-1:0] T_STB_HI = TW'(3);

  logic in_cycle_n, stb_win_n;

  always_comb begin
    in_cycle_n = (t_n != T_IDLE);
    stb_win_n  = (t_n >= T_STB_LO) && (t_n <= T_STB_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 3'b000;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      status <= in_cycle_n ? status_of(kind_n) : 3'b000;
      ale    <= (t_n == T_ADDR);
      rd_n   <= !(in_cycle_n && stb_win_n && is_rd(kind_n));
      wr_n   <= !(in_cycle_n && stb_win_n && is_wr(kind_n));
      done   <= in_cycle_n && (t_n == len_n);
    end
  end

  // R6: the two bus strobes are never active together
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R5: address strobe is a single-state pulse
  a_r5_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

endmodule

// File: rtl/bcs_rd_capture.sv
module bcs_rd_capture
  import bcs_pkg::*;
#(
  parameter int TW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] t_q,
  input  kind_e         kind_q,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] rdata
);

  localparam logic [TW-1:0] T_CAP = TW'(3);

  logic cap_en;
  assign cap_en = (t_q == T_CAP) && is_rd(kind_q);

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cap_en) rdata <= data_in;
  end

  // R7: outside a capture edge the read byte never moves
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(rdata));

endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import bcs_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3,
  localparam int TW     = $clog2(FETCH_T + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] data_in,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [TW-1:0] tstate,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] rdata,
  output logic          done
);

  localparam logic [TW-1:0] LEN_F  = TW'(FETCH_T);
  localparam logic [TW-1:0] LEN_X  = TW'(XFER_T);
  localparam logic [TW-1:0] T_IDLE = '0;
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  kind_e         kind_q, kind_n, req_k;
  logic          opened;
  logic          accept;
  logic [TW-1:0] t_q, t_n, len_q, len_n;
  logic [2:0]    status;

  assign req_k = kind_e'(req_kind);

  always_comb begin
    accept = (t_q == T_IDLE) && req_valid && kind_ok(req_kind)
             && (opened || req_k == K_FETCH);
    kind_n = accept ? req_k : kind_q;
    len_q  = (kind_q == K_FETCH) ? LEN_F : LEN_X;
    len_n  = (kind_n == K_FETCH) ? LEN_F : LEN_X;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_FETCH;
      opened <= 1'b0;
    end else if (accept) begin
      kind_q <= req_k;
      opened <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      data_out <= '0;
    end else if (t_n == T_IDLE) begin
      addr_out <= '0;
      data_out <= '0;
    end else if (accept) begin
      addr_out <= req_addr;
      data_out <= is_wr(req_k) ? req_wdata : '0;
    end
  end

  bcs_phase_ctr #(.TW(TW)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .len   (len_q),
    .t_q   (t_q),
    .t_n   (t_n)
  );

  bcs_strobe_gen #(.TW(TW)) u_stb (
    .clk    (clk),
    .rst    (rst),
    .t_n    (t_n),
    .len_n  (len_n),
    .kind_n (kind_n),
    .status (status),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .done   (done)
  );

  bcs_rd_capture #(.TW(TW), .DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .t_q     (t_q),
    .kind_q  (kind_q),
    .data_in (data_in),
    .rdata   (rdata)
  );

  assign {io_m, s1, s0} = status;
  assign tstate         = t_q;

  // R1: status and address stay fixed after the first state of a cycle
  a_r1_status_held: assert property (@(posedge clk) disable iff (rst)
    (tstate > T_ONE) |-> ($stable(status) && $stable(addr_out)));

  // R4: idle outputs
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (tstate == T_IDLE) |-> (status == 3'b000 && rd_n && wr_n && !ale && !done));

  // R8: done is followed by idle
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> (tstate == T_IDLE));

  // R9: no cycle begins straight after a busy state
  a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
    (tstate != T_IDLE) |=> (tstate != T_ONE));

  // R2: a fetch in state 3 always moves on to a strobe-free state 4
  a_r2_fetch_t4: assert property (@(posedge clk) disable iff (rst)
    (status == 3'b011 && tstate == TW'(3)) |=> (tstate == TW'(4) && rd_n && wr_n));

endmodule

// File: tb/sim_mcycle_seq.sv
module sim_mcycle_seq;

  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] data_in = '0;
  logic          io_m, s1, s0, ale, rd_n, wr_n, done;
  logic [2:0]    tstate;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] data_out, rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [DW-1:0] exp_rdata = '0;

  mcycle_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .data_in(data_in),
    .io_m(io_m), .s1(s1), .s0(s0), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .tstate(tstate), .addr_out(addr_out), .data_out(data_out),
    .rdata(rdata), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int exp_len(input logic [2:0] k);
    return (k == 3'd0) ? 4 : 3;
  endfunction

  function automatic logic k_rd(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
  endfunction

  function automatic logic k_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " tstate"}, 32'(tstate), 0);
    chk({req, " status"}, {29'd0, io_m, s1, s0}, 0);
    chk({req, " strobes"}, {29'd0, ale, rd_n, wr_n}, 32'b011);
    chk({req, " done"}, 32'(done), 0);
    chk({req, " bus"}, {8'd0, addr_out, data_out}, 0);
  endtask

  // Caller is at a falling edge. Runs one full cycle and checks each state.
  task automatic run_cycle(input logic [2:0] k, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rb,
                           input logic meddle);
    int len;
    logic [DW-1:0] prev;
    len  = exp_len(k);
    prev = exp_rdata;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; data_in = rb;
    for (int t = 1; t <= len; t++) begin
      @(negedge clk);
      if (meddle) begin
        // R9: a different request held high while busy
        req_kind = 3'((k + 3'd1 + 3'($urandom_range(0, 3))) % 5);
        req_addr = ~a; req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      chk("R1 status", {29'd0, io_m, s1, s0}, {29'd0, exp_status(k)});
      chk("R3 tstate", 32'(tstate), t);
      chk("R5 ale", 32'(ale), (t == 1));
      chk("R5 addr", 32'(addr_out), 32'(a));
      chk("R6 rd_n", 32'(rd_n), !(k_rd(k) && t >= 2 && t <= 3));
      chk("R6 wr_n", 32'(wr_n), !(k_wr(k) && t >= 2 && t <= 3));
      chk("R6 data_out", 32'(data_out), k_wr(k) ? 32'(wd) : 0);
      chk("R8 done", 32'(done), (t == len));
      if (t <= 3) chk("R7 rdata before capture", 32'(rdata), 32'(prev));
      else        chk("R7 R2 rdata in T4", 32'(rdata), 32'(rb));
    end
    if (k_rd(k)) exp_rdata = rb;
    @(negedge clk);
    req_valid = 1'b0;
    chk_idle("R8 R4 after done");
    chk("R7 rdata", 32'(rdata), 32'(exp_rdata));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= 200000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R11 R4 reset");
    chk("R11 rdata", 32'(rdata), 0);

    // R10: read before any fetch is ignored
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h1234;
    @(negedge clk);
    chk_idle("R10 locked");
    @(negedge clk);
    chk_idle("R10 locked again");
    req_valid = 1'b0;

    // R2: fetch, then each kind directed
    run_cycle(3'd0, 16'h0000, 8'h00, 8'h3e, 1'b0);
    run_cycle(3'd1, 16'hffff, 8'h00, 8'ha5, 1'b0);
    run_cycle(3'd2, 16'h8001, 8'h5a, 8'h11, 1'b0);
    run_cycle(3'd3, 16'h00fe, 8'h00, 8'hff, 1'b0);
    run_cycle(3'd4, 16'h0042, 8'hc3, 8'h22, 1'b0);
    // R7: write does not disturb rdata (checked inside), then back-to-back meddling
    run_cycle(3'd2, 16'h7777, 8'h01, 8'h99, 1'b1);
    run_cycle(3'd0, 16'h1000, 8'h00, 8'h76, 1'b1);

    // R9: invalid kinds ignored
    for (int c = 5; c <= 7; c++) begin
      req_valid = 1'b1; req_kind = 3'(c);
      @(negedge clk);
      req_valid = 1'b0;
      chk_idle("R9 invalid kind");
      chk("R9 rdata", 32'(rdata), 32'(exp_rdata));
    end

    // random cycles
    for (int i = 0; i < 60; i++) begin
      run_cycle(3'($urandom_range(0, 4)), 16'($urandom), 8'($urandom),
                8'($urandom), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk);
        chk_idle("R4 idle gap");
      end
    end

    // R11: reset in the middle of a write cycle
    req_valid = 1'b1; req_kind = 3'd4; req_addr = 16'hbeef; req_wdata = 8'h44;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 mid-cycle wr_n", 32'(wr_n), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R11 mid-cycle reset");
    chk("R11 rdata cleared", 32'(rdata), 0);
    exp_rdata = '0;

    // R10: lock-out returns after reset
    req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'h0003;
    @(negedge clk);
    req_valid = 1'b0;
    chk_idle("R10 locked after reset");
    run_cycle(3'd0, 16'h2000, 8'h00, 8'h0c, 1'b0);
    run_cycle(3'd3, 16'h0003, 8'h00, 8'hd7, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule